// File: doc/BRIEF.md
# Region-Aware Panel Raster Timing Generator

This block produces the raster for a flat-panel output. A frame is split vertically into three bands: top blanking, border and active video. Each band can run its own horizontal line period. A small write-only register port sets the three line periods, the frame height, the first line of the border and active bands, the horizontal offset at which vertical sync starts, and the width of the data-enable window. Every timing value is 11 bits wide.

The raster is driven by a four-state machine. `ST_OFF` is the idle state. `ST_TOP`, `ST_BORDER` and `ST_ACTIVE` each mean that the current line belongs to that band. The transitions are as follows:

- T_START leaves `ST_OFF` once the output is enabled. It loads the timing and enters the band of line 0.
- T_LINE moves at the end of each line to the band of the next line.
- T_FRAME happens at the end of the last line. It reloads the timing from the shadow copy and enters the band of line 0.
- T_STOP returns to `ST_OFF` from any band as soon as the output is disabled.

Timing writes land in a shadow copy and are used only from the next frame start. The output-enable and forced-black controls act at once.

Top module: `panel_timing_gen`

## Requirements
- R1: After reset, and from the cycle after the output-enable bit (control bit 3, address 0) is seen clear, hsync, vsync, de, the region flags and pix_o are all 0.
- R2: When a band's override bit is set, lines of that band last exactly the value written for that band, in clocks. The override bit is control bit 0 for top blanking and control bit 1 for border. The top length is at address 1 and the border length is at address 2.
- R3: When a band's override bit is clear, lines of that band last the active line length (address 3).
- R4: A frame has the number of lines at address 4. Lines below the value at address 5 are top blanking. Lines from that value up to, but not including, the value at address 6 are border. The remaining lines are active. Exactly one region flag is high while running.
- R5: hsync is high for the first HS_W clocks of every line.
- R6: vsync is high from column D of line 0 up to, but not including, column D of line 1. D is the value at address 7.
- R7: de is high on active lines for columns below the width at address 8.
- R8: When control bit 2 is set, de is also high whenever vsync is high.
- R9: While the forced-black bit (control bit 4) is set, pix_o is 0 from the cycle after the write.
- R10: pix_o equals pix_i when de is high and forced-black is clear. Otherwise pix_o is 0.
- R11: Writes to addresses 1 to 8 and to control bits 0 to 2 have no effect until the next frame start. A frame never mixes old and new timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 11 | Register write data |
| pix_i | input | PIX_W | Incoming pixel data |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync, delayed start |
| de_o | output | 1 | Data-enable qualifier |
| rgn_top_o | output | 1 | Current line is top blanking |
| rgn_border_o | output | 1 | Current line is border |
| rgn_active_o | output | 1 | Current line is active video |
| pix_o | output | PIX_W | Gated pixel data |

## Verification
Two events can fall in the same clock edge: the end of the last active line, which reloads the shadow timing, and the choice of band and line period for line 0 of the next frame. The bench provokes this by rewriting the top-band length, the sync offset and the override bits in the middle of a frame. Its cycle model keeps a pending copy of the configuration and a current copy, and swaps them only at the wrap. A design that applied the write early, or that took the band of line 0 from the old timing, would put the first hsync of the next line on the wrong clock. A second overlap comes from raising forced-black inside the data-enable window: de must stay high while pix_o drops to zero.

// File: rtl/ptg_pkg.sv
package ptg_pkg;
    localparam int PTG_W  = 11;
    localparam int PTG_AW = 4;

    localparam logic [PTG_AW-1:0] A_CTRL   = 4'd0;
    localparam logic [PTG_AW-1:0] A_TOPLEN = 4'd1;
    localparam logic [PTG_AW-1:0] A_BRDLEN = 4'd2;
    localparam logic [PTG_AW-1:0] A_ACTLEN = 4'd3;
    localparam logic [PTG_AW-1:0] A_LINES  = 4'd4;
    localparam logic [PTG_AW-1:0] A_BRDBEG = 4'd5;
    localparam logic [PTG_AW-1:0] A_ACTBEG = 4'd6;
    localparam logic [PTG_AW-1:0] A_VSDLY  = 4'd7;
    localparam logic [PTG_AW-1:0] A_DEWID  = 4'd8;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_TOP,
        ST_BORDER,
        ST_ACTIVE
    } ptg_state_t;

    typedef struct packed {
        logic             top_ovr;
        logic             brd_ovr;
        logic             de_in_vs;
        logic [PTG_W-1:0] top_len;
        logic [PTG_W-1:0] brd_len;
        logic [PTG_W-1:0] act_len;
        logic [PTG_W-1:0] lines;
        logic [PTG_W-1:0] brd_beg;
        logic [PTG_W-1:0] act_beg;
        logic [PTG_W-1:0] vs_dly;
        logic [PTG_W-1:0] de_wid;
    } ptg_cfg_t;
endpackage

// File: rtl/ptg_regs.sv
module ptg_regs
    import ptg_pkg::*;
#(
    parameter int DEF_LEN   = 16,
    parameter int DEF_LINES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [PTG_AW-1:0] addr,
    input  logic [PTG_W-1:0]  wdata,
    output ptg_cfg_t          shadow,
    output logic              out_en,
    output logic              blank
);
    localparam logic [PTG_W-1:0] L_DEF_LEN   = PTG_W'(DEF_LEN);
    localparam logic [PTG_W-1:0] L_DEF_LINES = PTG_W'(DEF_LINES);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow.top_ovr  <= 1'b0;
            shadow.brd_ovr  <= 1'b0;
            shadow.de_in_vs <= 1'b0;
            shadow.top_len  <= L_DEF_LEN;
            shadow.brd_len  <= L_DEF_LEN;
            shadow.act_len  <= L_DEF_LEN;
            shadow.lines    <= L_DEF_LINES;
            shadow.brd_beg  <= '0;
            shadow.act_beg  <= '0;
            shadow.vs_dly   <= '0;
            shadow.de_wid   <= L_DEF_LEN;
            out_en          <= 1'b0;
            blank           <= 1'b0;
        end else if (we) begin
            case (addr)
                A_CTRL: begin
                    shadow.top_ovr  <= wdata[0];
                    shadow.brd_ovr  <= wdata[1];
                    shadow.de_in_vs <= wdata[2];
                    out_en          <= wdata[3];
                    blank           <= wdata[4];
                end
                A_TOPLEN: shadow.top_len <= wdata;
                A_BRDLEN: shadow.brd_len <= wdata;
                A_ACTLEN: shadow.act_len <= wdata;
                A_LINES:  shadow.lines   <= wdata;
                A_BRDBEG: shadow.brd_beg <= wdata;
                A_ACTBEG: shadow.act_beg <= wdata;
                A_VSDLY:  shadow.vs_dly  <= wdata;
                A_DEWID:  shadow.de_wid  <= wdata;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/ptg_raster.sv
module ptg_raster
    import ptg_pkg::*;
#(
    parameter int HS_W = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     out_en,
    input  ptg_cfg_t shadow,
    output logic     hsync,
    output logic     vsync,
    output logic     de,
    output logic     rgn_top,
    output logic     rgn_border,
    output logic     rgn_active
);
    localparam logic [PTG_W-1:0] L_HS_W = PTG_W'(HS_W);

    ptg_state_t       st;
    ptg_cfg_t         wk;
    logic [PTG_W-1:0] hcnt;
    logic [PTG_W-1:0] vcnt;
    logic [PTG_W-1:0] line_len;
    logic             line_end;
    logic             frame_end;
    logic [PTG_W-1:0] vnext;

    function automatic ptg_state_t band_of(input logic [PTG_W-1:0] v, input ptg_cfg_t c);
        if (v < c.brd_beg)      return ST_TOP;
        else if (v < c.act_beg) return ST_BORDER;
        else                    return ST_ACTIVE;
    endfunction

    always_comb begin
        line_len = wk.act_len;
        if (st == ST_TOP && wk.top_ovr)    line_len = wk.top_len;
        if (st == ST_BORDER && wk.brd_ovr) line_len = wk.brd_len;
        line_end  = (hcnt == line_len - 1'b1);
        frame_end = line_end && (vcnt == wk.lines - 1'b1);
        vnext     = vcnt + 1'b1;
    end

    // State register: T_START, T_LINE, T_FRAME, T_STOP
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= ST_OFF;
            wk   <= '0;
            hcnt <= '0;
            vcnt <= '0;
        end else if (!out_en) begin
            st   <= ST_OFF;
            hcnt <= '0;
            vcnt <= '0;
        end else begin
            unique case (st)
                ST_OFF: begin
                    wk   <= shadow;
                    st   <= band_of('0, shadow);
                    hcnt <= '0;
                    vcnt <= '0;
                end
                ST_TOP, ST_BORDER, ST_ACTIVE: begin
                    if (frame_end) begin
                        wk   <= shadow;
                        st   <= band_of('0, shadow);
                        hcnt <= '0;
                        vcnt <= '0;
                    end else if (line_end) begin
                        st   <= band_of(vnext, wk);
                        hcnt <= '0;
                        vcnt <= vnext;
                    end else begin
                        hcnt <= hcnt + 1'b1;
                    end
                end
            endcase
        end
    end

    // Output decode
    always_comb begin
        logic run;
        run        = (st != ST_OFF);
        hsync      = run && (hcnt < L_HS_W);
        vsync      = run && (((vcnt == '0) && (hcnt >= wk.vs_dly)) ||
                             ((vcnt == PTG_W'(1)) && (hcnt < wk.vs_dly)));
        de         = run && (((st == ST_ACTIVE) && (hcnt < wk.de_wid)) ||
                             (wk.de_in_vs && vsync));
        rgn_top    = (st == ST_TOP);
        rgn_border = (st == ST_BORDER);
        rgn_active = (st == ST_ACTIVE);
    end

    p_stop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |=> (st == ST_OFF));

    p_hcnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_OFF) |-> (hcnt < line_len));

    p_frame_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_en && st != ST_OFF && frame_end) |=> (vcnt == '0 && hcnt == '0));

    p_vs_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vsync) |-> (vcnt == '0 && hcnt == wk.vs_dly));

    p_de_band_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (de && !vsync) |-> (st == ST_ACTIVE));

    p_hold_timing_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_en && st != ST_OFF && !frame_end) |=> $stable(wk));
endmodule

// File: rtl/panel_timing_gen.sv
module panel_timing_gen
    import ptg_pkg::*;
#(
    parameter int PIX_W     = 24,
    parameter int HS_W      = 4,
    parameter int DEF_LEN   = 16,
    parameter int DEF_LINES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [PTG_AW-1:0] cfg_addr,
    input  logic [PTG_W-1:0]  cfg_wdata,
    input  logic [PIX_W-1:0]  pix_i,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              de_o,
    output logic              rgn_top_o,
    output logic              rgn_border_o,
    output logic              rgn_active_o,
    output logic [PIX_W-1:0]  pix_o
);
    ptg_cfg_t shadow;
    logic     out_en;
    logic     blank;

    ptg_regs #(
        .DEF_LEN  (DEF_LEN),
        .DEF_LINES(DEF_LINES)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .shadow(shadow),
        .out_en(out_en),
        .blank (blank)
    );

    ptg_raster #(
        .HS_W(HS_W)
    ) u_raster (
        .clk       (clk),
        .rst_n     (rst_n),
        .out_en    (out_en),
        .shadow    (shadow),
        .hsync     (hsync_o),
        .vsync     (vsync_o),
        .de        (de_o),
        .rgn_top   (rgn_top_o),
        .rgn_border(rgn_border_o),
        .rgn_active(rgn_active_o)
    );

    always_comb begin
        pix_o = (de_o && !blank) ? pix_i : '0;
    end

    p_black_r9: assert property (@(posedge clk) disable iff (!rst_n)
        blank |-> (pix_o == '0));

    p_one_band_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rgn_top_o, rgn_border_o, rgn_active_o}));
endmodule

// File: tb/test_panel_timing_gen.sv
`timescale 1ns/1ps
module test_panel_timing_gen;
    localparam int PW  = 24;
    localparam int HSW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [3:0]    cfg_addr = '0;
    logic [10:0]   cfg_wdata = '0;
    logic [PW-1:0] pix_in = '0;
    logic          hsync, vsync, de, r_top, r_brd, r_act;
    logic [PW-1:0] pix_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int pc[8];
    int cc[8];
    int p_ctl = 0;
    int c_ctl = 0;
    bit oe_m = 0;
    bit blank_m = 0;
    bit running = 0;
    int h = 0;
    int v = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    panel_timing_gen #(.PIX_W(PW), .HS_W(HSW), .DEF_LEN(16), .DEF_LINES(8)) i_panel_timing_gen (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .pix_i(pix_in), .hsync_o(hsync), .vsync_o(vsync),
        .de_o(de), .rgn_top_o(r_top), .rgn_border_o(r_brd), .rgn_active_o(r_act),
        .pix_o(pix_out)
    );

    function automatic int band_m(input int vv);
        if (vv < cc[4]) return 0;
        if (vv < cc[5]) return 1;
        return 2;
    endfunction

    function automatic int len_m();
        int b;
        b = band_m(v);
        if (b == 0 && c_ctl[0]) return cc[0];
        if (b == 1 && c_ctl[1]) return cc[1];
        return cc[2];
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at cycle %0d h=%0d v=%0d: got %0h expected %0h", tag, cyc, h, v, act, exp);
        end
    endtask

    task automatic compare();
        bit hs, vs, dq;
        int b;
        logic [PW-1:0] px;
        if (!running) begin
            chk(hsync == 0 && vsync == 0 && de == 0, "R1 syncs", {hsync, vsync, de}, 0);
            chk({r_top, r_brd, r_act} == 3'b000, "R1 flags", {r_top, r_brd, r_act}, 0);
            chk(pix_out == '0, "R1 pixel", pix_out, 0);
            return;
        end
        b  = band_m(v);
        hs = (h < HSW);
        vs = (v == 0 && h >= cc[6]) || (v == 1 && h < cc[6]);
        dq = (b == 2 && h < cc[7]) || (c_ctl[2] && vs);
        px = (dq && !blank_m) ? pix_in : '0;
        if (h == 0)
            chk(hsync == 1'b1, (b < 2 && c_ctl[b]) ? "R2 line period" : "R3 line period", hsync, 1);
        else
            chk(hsync == hs, "R5 hsync", hsync, hs);
        chk(vsync == vs, "R6 vsync", vsync, vs);
        chk(de == dq, (c_ctl[2] && vs) ? "R8 de in vsync" : "R7 de window", de, dq);
        chk(pix_out == px, blank_m ? "R9 forced black" : "R10 pixel pass", pix_out, px);
        chk({r_top, r_brd, r_act} == 3'(1 << (2 - b)), (h == 0 && v == 0) ? "R11 frame start band" : "R4 band",
            {r_top, r_brd, r_act}, 1 << (2 - b));
    endtask

    task automatic step(input bit we, input int a, input int d);
        @(negedge clk);
        cfg_we    = we;
        cfg_addr  = 4'(a);
        cfg_wdata = 11'(d);
        pix_in    = PW'(cyc * 40503 + 17);
        #1;
        compare();
        @(posedge clk);
        cyc++;
        if (running && !oe_m) begin
            running = 0; h = 0; v = 0;
        end else if (!running && oe_m) begin
            running = 1; h = 0; v = 0; cc = pc; c_ctl = p_ctl;
        end else if (running) begin
            if (h == len_m() - 1) begin
                h = 0;
                if (v == cc[3] - 1) begin
                    v = 0; cc = pc; c_ctl = p_ctl;
                end else v++;
            end else h++;
        end
        if (we) begin
            if (a == 0) begin
                p_ctl = d; oe_m = d[3]; blank_m = d[4];
            end else pc[a-1] = d;
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog expired: got 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        pc = '{16, 16, 16, 8, 0, 0, 0, 16};
        cc = pc;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        run(4);                                     // R1 idle after reset
        step(1, 1, 12); step(1, 2, 10); step(1, 3, 14); step(1, 4, 9);
        step(1, 5, 2);  step(1, 6, 4);  step(1, 7, 5);  step(1, 8, 9);
        step(1, 0, 5'b01011);                       // overrides on, output on
        run(130);                                   // R2 R4 R5 R6 R7 R10
        step(1, 0, 5'b01111);                       // R8 pending until next frame
        step(1, 1, 7);                              // R11 new top length pending
        step(1, 7, 3);
        run(250);
        step(1, 0, 5'b11111);                       // R9 forced black
        run(60);
        step(1, 0, 5'b01111);
        run(20);
        step(1, 0, 5'b01100);                       // R3 overrides off
        run(250);
        step(1, 4, 6); step(1, 6, 3); step(1, 8, 14);
        run(200);
        step(1, 0, 5'b00100);                       // R1 output off
        run(6);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule